// File: doc/BRIEF.md
# Throttled strided vector request issuer

This block expands one vector memory access into a sequence of single-word requests for a banked shared-memory network. A command carries the access type (fetch or write), a base word address, a stride and an element count, all measured in 8-byte words. The block walks the addresses `base`, `base + stride`, `base + 2*stride` and so on. For every element it presents one request that carries the full word address, the bank it maps to, the word offset inside that bank, and the type.

Injection is metered. A credit counter tracks requests that the network has taken but that have not yet been answered by a reply strobe. No new request is offered while that count equals a run-time limit, which resets to 8 and can only be rewritten between vector accesses. This caps the traffic one processor keeps in flight instead of flooding the network with a whole burst.

Both streaming interfaces use valid/ready. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only while no access is running. A request moves on a cycle where `req_valid` and `req_ready` are both high. Once `req_valid` is raised, it stays high with an unchanged payload until the network takes it, so the network may stall for any number of cycles. The limit write, the reply strobe and the status pins are plain single-cycle signals.

Top module: `vreq_issuer`

## Requirements
- R1: After reset `cmd_ready`=1 and `busy`, `done`, `req_valid` and `rsp_err` are all 0; the in-flight limit is 8.
- R2: A command of length N produces exactly N accepted requests. Request i (from 0) carries word address (base + i*stride) mod 2^ADDR_W, and `req_write` equals the command's `cmd_write` (1 = write, 0 = fetch).
- R3: `req_bank` equals bits [4:0] of `req_addr` (32 banks, word-interleaved), and `req_offset` equals `req_addr` shifted right by 5.
- R4: The in-flight count rises by one on each accepted request and falls by one on each reply. When both happen in one cycle the count is unchanged. `req_valid` is never high while the count equals the limit.
- R5: While `req_valid`=1 and `req_ready`=0, the next cycle still has `req_valid`=1 with the same `req_addr` and `req_write`.
- R6: `busy` is 1 from the cycle after a nonzero-length command is accepted until the last request has been issued and the in-flight count has returned to zero. The cycle after that, `done` rises and stays high until the next command is accepted. `cmd_ready` equals NOT `busy`.
- R7: A zero-length command issues no request, and `done`=1 with `busy`=0 on the cycle after it is accepted.
- R8: A pulse on `lim_wr` loads `lim_data` into the limit only when `busy`=0 and `lim_data` is nonzero. Otherwise the pulse has no effect.
- R9: A reply strobe that arrives while the in-flight count is zero sets `rsp_err` and leaves the count unchanged. `rsp_err` stays set until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (no access running) |
| cmd_write | input | 1 | 1 = write access, 0 = fetch |
| cmd_base | input | ADDR_W | Base word address |
| cmd_stride | input | ADDR_W | Word stride, modulo 2^ADDR_W |
| cmd_len | input | LEN_W | Element count |
| lim_wr | input | 1 | Load strobe for the in-flight limit |
| lim_data | input | CNT_W | New in-flight limit |
| req_valid | output | 1 | Word request offered |
| req_ready | input | 1 | Network takes the request |
| req_addr | output | ADDR_W | Word address |
| req_bank | output | BANK_W | Bank index |
| req_offset | output | ADDR_W-BANK_W | Word offset inside the bank |
| req_write | output | 1 | Request type |
| rsp_strobe | input | 1 | One reply returned |
| busy | output | 1 | Access in progress |
| done | output | 1 | Last access finished |
| rsp_err | output | 1 | Unmatched reply seen |

## Verification
The checker assumes the command port is not driven while `cmd_ready` is low. It also assumes a stall on the request port comes only from the network holding `req_ready` low. Replies are not assumed to be well behaved, so a spurious reply is a defined input that the error property covers. The bench keeps an in-flight tally of its own and strobes a reply only while that tally is positive. The one exception is the deliberate stray-reply test, which is run while the block is idle.

// File: rtl/vri_pkg.sv
package vri_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } vri_state_t;
endpackage

// File: rtl/vri_addr_gen.sv
module vri_addr_gen #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LEN_W-1:0]  len,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              all_issued
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] stride_q;
  logic [LEN_W-1:0]  left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stride_q <= '0;
      left_q   <= '0;
    end else if (load) begin
      addr_q   <= base;
      stride_q <= stride;
      left_q   <= len;
    end else if (step && left_q != '0) begin
      addr_q <= addr_q + stride_q;
      left_q <= left_q - 1'b1;
    end
  end

  assign addr       = addr_q;
  assign all_issued = (left_q == '0);
endmodule

// File: rtl/vri_credit.sv
module vri_credit #(
  parameter int CNT_W     = 5,
  parameter int DEF_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             give,
  input  logic             cfg_open,
  input  logic             lim_wr,
  input  logic [CNT_W-1:0] lim_data,
  input  logic             clr_err,
  output logic [CNT_W-1:0] inflight,
  output logic [CNT_W-1:0] limit,
  output logic             has_credit,
  output logic             err
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             err_q;
  logic             give_ok;

  assign give_ok = give && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case ({take, give_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q <= CNT_W'(DEF_LIMIT);
    end else if (lim_wr && cfg_open && lim_data != '0) begin
      lim_q <= lim_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (clr_err) begin
      err_q <= 1'b0;
    end else if (give && !give_ok) begin
      err_q <= 1'b1;
    end
  end

  assign inflight   = cnt_q;
  assign limit      = lim_q;
  assign has_credit = (cnt_q < lim_q);
  assign err        = err_q;
endmodule

// File: rtl/vri_bank_map.sv
module vri_bank_map #(
  parameter int ADDR_W = 24,
  parameter int BANKS  = 32
) (
  input  logic [ADDR_W-1:0]                addr,
  output logic [$clog2(BANKS)-1:0]         bank,
  output logic [ADDR_W-$clog2(BANKS)-1:0]  offset
);
  localparam int BANK_W = $clog2(BANKS);
  localparam bit POW2   = ((1 << BANK_W) == BANKS);

  generate
    if (POW2) begin : g_pow2
      assign bank   = addr[BANK_W-1:0];
      assign offset = addr[ADDR_W-1:BANK_W];
    end else begin : g_mod
      logic [ADDR_W-1:0] quo;
      logic [ADDR_W-1:0] rem;
      assign quo    = addr / ADDR_W'(BANKS);
      assign rem    = addr % ADDR_W'(BANKS);
      assign bank   = rem[BANK_W-1:0];
      assign offset = quo[ADDR_W-BANK_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/vreq_issuer.sv
module vreq_issuer
  import vri_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int LEN_W     = 12,
  parameter int CNT_W     = 5,
  parameter int BANKS     = 32,
  parameter int DEF_LIMIT = 8,
  localparam int BANK_W   = $clog2(BANKS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic                     cmd_write,
  input  logic [ADDR_W-1:0]        cmd_base,
  input  logic [ADDR_W-1:0]        cmd_stride,
  input  logic [LEN_W-1:0]         cmd_len,
  input  logic                     lim_wr,
  input  logic [CNT_W-1:0]         lim_data,
  output logic                     req_valid,
  input  logic                     req_ready,
  output logic [ADDR_W-1:0]        req_addr,
  output logic [BANK_W-1:0]        req_bank,
  output logic [ADDR_W-BANK_W-1:0] req_offset,
  output logic                     req_write,
  input  logic                     rsp_strobe,
  output logic                     busy,
  output logic                     done,
  output logic                     rsp_err
);
  vri_state_t       state_q;
  logic             write_q;
  logic             accept;
  logic             fire;
  logic             all_issued;
  logic             has_credit;
  logic [CNT_W-1:0] out_cnt;
  logic [CNT_W-1:0] lim_q;

  assign cmd_ready = (state_q != ST_RUN);
  assign accept    = cmd_valid && cmd_ready;
  assign busy      = (state_q == ST_RUN);
  assign done      = (state_q == ST_DONE);
  assign req_valid = busy && !all_issued && has_credit;
  assign fire      = req_valid && req_ready;
  assign req_write = write_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
    end else begin
      if (accept) begin
        write_q <= cmd_write;
        state_q <= (cmd_len == '0) ? ST_DONE : ST_RUN;
      end else if (state_q == ST_RUN && all_issued && out_cnt == '0) begin
        state_q <= ST_DONE;
      end
    end
  end

  vri_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_agen (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .base       (cmd_base),
    .stride     (cmd_stride),
    .len        (cmd_len),
    .step       (fire),
    .addr       (req_addr),
    .all_issued (all_issued)
  );

  vri_credit #(.CNT_W(CNT_W), .DEF_LIMIT(DEF_LIMIT)) u_credit (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (fire),
    .give       (rsp_strobe),
    .cfg_open   (!busy),
    .lim_wr     (lim_wr),
    .lim_data   (lim_data),
    .clr_err    (accept),
    .inflight   (out_cnt),
    .limit      (lim_q),
    .has_credit (has_credit),
    .err        (rsp_err)
  );

  vri_bank_map #(.ADDR_W(ADDR_W), .BANKS(BANKS)) u_bmap (
    .addr   (req_addr),
    .bank   (req_bank),
    .offset (req_offset)
  );
endmodule

// File: rtl/vri_checker.sv
module vri_checker #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [LEN_W-1:0]  cmd_len,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              rsp_strobe,
  input logic              busy,
  input logic              done,
  input logic              rsp_err,
  input logic [CNT_W-1:0]  out_cnt,
  input logic [CNT_W-1:0]  lim_q
);
  assert_credit_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> out_cnt < lim_q);

  assert_same_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && rsp_strobe && out_cnt != '0) |=> $stable(out_cnt));

  assert_hold_payload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(req_addr) && $stable(req_write));

  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid && out_cnt == '0 && cmd_ready);

  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_len != '0) |=> busy && !cmd_ready);

  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_len == '0) |=> done && !busy);

  assert_limit_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(lim_q));

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_err) |-> $past(rsp_strobe) && $past(out_cnt) == '0);
endmodule

bind vreq_issuer vri_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_len    (cmd_len),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_write  (req_write),
  .rsp_strobe (rsp_strobe),
  .busy       (busy),
  .done       (done),
  .rsp_err    (rsp_err),
  .out_cnt    (out_cnt),
  .lim_q      (lim_q)
);

// File: tb/tb_vreq_issuer.sv
`timescale 1ns/1ps
module tb_vreq_issuer;
  localparam int ADDR_W = 24;
  localparam int LEN_W  = 12;
  localparam int CNT_W  = 5;
  localparam int BANK_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic cmd_write = 1'b0;
  logic [ADDR_W-1:0] cmd_base = '0;
  logic [ADDR_W-1:0] cmd_stride = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic lim_wr = 1'b0;
  logic [CNT_W-1:0] lim_data = '0;
  logic req_valid;
  logic req_ready = 1'b0;
  logic [ADDR_W-1:0] req_addr;
  logic [BANK_W-1:0] req_bank;
  logic [ADDR_W-BANK_W-1:0] req_offset;
  logic req_write;
  logic rsp_strobe = 1'b0;
  logic busy, done, rsp_err;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  vreq_issuer dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_len(cmd_len),
    .lim_wr(lim_wr), .lim_data(lim_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_bank(req_bank), .req_offset(req_offset), .req_write(req_write),
    .rsp_strobe(rsp_strobe), .busy(busy), .done(done), .rsp_err(rsp_err)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_limit(input int val);
    @(negedge clk);
    lim_wr = 1'b1; lim_data = CNT_W'(val);
    @(negedge clk);
    lim_wr = 1'b0;
  endtask

  task automatic start_cmd(input bit wr, input int base, input int stride, input int len);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr;
    cmd_base = ADDR_W'(base); cmd_stride = ADDR_W'(stride); cmd_len = LEN_W'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(rsp_err == 1'b0, "R9 err cleared on accept", rsp_err, 0);
  endtask

  // Full access with varying ready and reply patterns; checks every request.
  task automatic run_cmd(input bit wr, input int base, input int stride, input int len,
                         input int lim, input int pat);
    int issued = 0, inflight = 0, cyc = 0;
    int cap_bad = 0, pay_bad = 0, hold_bad = 0, busy_bad = 0;
    bit prev_stall = 0;
    logic [ADDR_W-1:0] prev_a = '0;
    logic [ADDR_W-1:0] exp_a;
    bit v, rdy, rsp, fire;
    start_cmd(wr, base, stride, len);
    if (len == 0) begin
      check(done && !busy && !req_valid, "R7 zero length done next cycle", done, 1);
      return;
    end
    while (!done && cyc < 2000) begin
      v = req_valid;
      if (!busy || cmd_ready) busy_bad++;
      rdy = ((cyc + pat) % 4) != 1 && ((cyc * pat) % 5) != 3;
      rsp = (inflight > 0) && (((cyc + 2 * pat) % 3) != 0);
      req_ready = rdy; rsp_strobe = rsp;
      if (v && inflight >= lim) cap_bad++;
      if (prev_stall && (!v || req_addr != prev_a)) hold_bad++;
      fire = v && rdy;
      if (fire) begin
        exp_a = ADDR_W'(base + issued * stride);
        if (req_addr != exp_a || req_write != wr ||
            req_bank != exp_a[BANK_W-1:0] || req_offset != exp_a[ADDR_W-1:BANK_W])
          pay_bad++;
        issued++;
      end
      prev_stall = v && !rdy;
      prev_a = req_addr;
      inflight = inflight + (fire ? 1 : 0) - (rsp ? 1 : 0);
      cyc++;
      @(negedge clk);
      req_ready = 1'b0; rsp_strobe = 1'b0;
    end
    check(done == 1'b1, "R6 done reached", done, 1);
    check(issued == len, "R2 request count", issued, len);
    check(pay_bad == 0, "R2/R3 address, bank, offset, type", pay_bad, 0);
    check(cap_bad == 0, "R4 no request at limit", cap_bad, 0);
    check(hold_bad == 0, "R5 stalled request held", hold_bad, 0);
    check(busy_bad == 0 && inflight == 0, "R6 busy until drained", busy_bad, 0);
    check(cmd_ready && !busy, "R6 ready after done", cmd_ready, 1);
  endtask

  // Holds replies back to measure how many requests get out; optionally
  // tries a limit write mid-access.
  task automatic cap_test(input int len, input int exp_cap, input bit poke, input string tag);
    int fires = 0, inflight = 0, cyc = 0;
    start_cmd(1'b0, 100, 1, len);
    req_ready = 1'b1;
    for (int i = 0; i < 30; i++) begin
      lim_wr = poke && (i == 2);
      lim_data = CNT_W'(20);
      if (req_valid) fires++;
      @(negedge clk);
    end
    lim_wr = 1'b0;
    check(fires == exp_cap, tag, fires, exp_cap);
    inflight = fires;
    while (!done && cyc < 2000) begin
      rsp_strobe = (inflight > 0);
      if (req_valid) inflight++;
      if (rsp_strobe) inflight--;
      cyc++;
      @(negedge clk);
    end
    req_ready = 1'b0; rsp_strobe = 1'b0;
    check(done == 1'b1, "R6 capped access drains to done", done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lims [4] = '{1, 2, 3, 8};
    int strides [5] = '{0, 1, 5, 33, -1};
    int lens [4] = '{0, 1, 7, 13};
    int pat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1 reset cmd_ready", cmd_ready, 1);
    check(!busy && !done && !req_valid && !rsp_err, "R1 reset status low",
          {busy, done, req_valid, rsp_err}, 0);

    cap_test(12, 8, 1'b0, "R1/R8 default limit of 8");
    check(done == 1'b1, "R6 done held while idle", done, 1);
    write_limit(0);
    cap_test(12, 8, 1'b0, "R8 zero limit write ignored");
    write_limit(3);
    cap_test(10, 3, 1'b1, "R8 limit write while busy ignored");
    cap_test(10, 20 > 10 ? 3 : 3, 1'b0, "R8 limit kept after busy write");

    @(negedge clk);
    rsp_strobe = 1'b1;
    @(negedge clk);
    rsp_strobe = 1'b0;
    check(rsp_err == 1'b1, "R9 stray reply flagged", rsp_err, 1);
    write_limit(8);
    @(negedge clk);
    check(rsp_err == 1'b1, "R9 error sticky while idle", rsp_err, 1);
    cap_test(12, 8, 1'b0, "R9 stray reply left count at zero");

    foreach (lims[a]) begin
      write_limit(lims[a]);
      foreach (strides[b]) begin
        foreach (lens[c]) begin
          run_cmd(pat[0], 24'h00F0 + pat * 37, strides[b], lens[c], lims[a], pat);
          pat++;
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule